// File: doc/BRIEF.md
# Zero-Page and Stack Dual-Read Store

This block is a small on-chip copy of the two lowest 256-byte pages of an 8-bit processor's 64 KB address space: page 0, where the zero page lives, and page 1, where the stack lives. It sits beside the external memory path. A core can therefore fetch a zero-page pointer or pull stack bytes while the external bus is busy with an opcode or operand fetch. Each page has its own bank. Every bank is split into an even-offset half and an odd-offset half, so any two adjacent bytes, aligned or not, come out in one cycle as a little-endian 16-bit word.

Every port decodes a full 16-bit address. When the upper address byte is 0x00 or 0x01, the access is routed to the internal bank, whatever addressing mode produced it. Absolute, indexed, zero-page and stack accesses therefore all see the same bytes. Any other address raises an external flag, and the banks ignore that access. The store has two read ports and one byte-wide write port. A 16-bit store, such as a pushed return address, takes two back-to-back byte writes. A word read keeps its second byte inside the same page, so a pointer at offset 0xFF takes its high byte from offset 0x00 of that page.

Top module: `zp_stack_store`

## Requirements
- R1: Addresses 0x0000–0x00FF are held in one bank and 0x0100–0x01FF in another. Writing a byte in one page leaves the byte at the same offset in the other page unchanged.
- R2: Each port's hit output is 1 in the same cycle exactly when address bits 15:8 equal 0x00 or 0x01. Each read port's ext output is the inverse of its hit. w_ext is 1 exactly when w_en is 1 and the write address is outside both pages.
- R3: A byte read (word input 0) of an internal address returns the stored byte in data bits 7:0, on the cycle after the address is presented, with bits 15:8 equal to zero.
- R4: A word read (word input 1) at offset k returns the byte at offset k in bits 7:0 and the byte at offset k+1 in bits 15:8, one cycle later, for both even and odd k.
- R5: A word read at 0x00FF takes its high byte from 0x0000, not from 0x0100.
- R6: A word read at 0x01FF takes its high byte from 0x0100.
- R7: The two read ports work independently in the same cycle, whether they address the same page or different pages.
- R8: A write stores one byte per cycle. Two writes on consecutive cycles to offsets k and k+1 are then returned together by a word read at k.
- R9: A read in the same cycle as a write to the same byte returns the newly written byte, in either lane of either read port.
- R10: A write whose address is outside pages 0 and 1 changes no stored byte. A read of such an address returns all-zero data on the next cycle.
- R11: While rst_n is low, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset for the read data registers |
| a_addr | input | 16 | Read port A address |
| a_word | input | 1 | Read port A: 1 = two adjacent bytes, 0 = one byte |
| a_hit | output | 1 | Read port A address lies in page 0 or 1 |
| a_ext | output | 1 | Read port A access belongs to external memory |
| a_data | output | 16 | Read port A data, registered, little-endian |
| b_addr | input | 16 | Read port B address |
| b_word | input | 1 | Read port B: 1 = two adjacent bytes, 0 = one byte |
| b_hit | output | 1 | Read port B address lies in page 0 or 1 |
| b_ext | output | 1 | Read port B access belongs to external memory |
| b_data | output | 16 | Read port B data, registered, little-endian |
| w_en | input | 1 | Write strobe |
| w_addr | input | 16 | Write address |
| w_data | input | 8 | Write byte |
| w_ext | output | 1 | Write strobe aimed at external memory |

## Verification
Assertions check these properties on every cycle:
- At most one bank takes a write, and an external write reaches no bank.
- A byte read always returns a zero upper byte, and an external read always returns zero data.
- Same-byte bypass holds on port A's low lane and on the high lane of a bank's word read.
- A written sub-memory entry holds its byte on the next cycle.

Other properties depend on stored contents across many cycles, so only the bench's scenarios can show them:
- The two pages stay separate.
- Pointers at 0x00FF and 0x01FF wrap inside their page.
- Back-to-back byte writes form a readable word.
- An ignored external write leaves the banks intact.

// File: rtl/zps_pkg.sv
package zps_pkg;
  localparam int ADDR_W     = 16;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int OFF_W      = 8;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int DEPTH      = 1 << OFF_W;
  localparam int HALF_W     = OFF_W - 1;
  localparam int HALF_DEPTH = DEPTH / 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [PAGE_W-1:0] page_t;

  // upper address byte: which 256-byte page an address falls in
  function automatic page_t page_of(addr_t a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  // byte position inside the page
  function automatic off_t off_of(addr_t a);
    return a[OFF_W-1:0];
  endfunction

  // successor offset, wrapping inside the same page
  function automatic off_t next_off(off_t o);
    return off_t'(o + 1'b1);
  endfunction

  // write-first selection for one read lane
  function automatic byte_t pick_byte(logic we, off_t woff, byte_t wdata,
                                      off_t roff, byte_t stored);
    return (we && (woff == roff)) ? wdata : stored;
  endfunction
endpackage

// File: rtl/zps_decode.sv
module zps_decode
  import zps_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  localparam int SEL_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              ext,
  output logic [SEL_W-1:0]  sel,
  output logic [OFF_W-1:0]  off
);
  page_t pg;

  always_comb begin
    pg  = page_of(addr);
    hit = (int'(pg) < NUM_PAGES);
    ext = !hit;
    sel = pg[SEL_W-1:0];
    off = off_of(addr);
  end
endmodule

// File: rtl/zps_submem.sv
module zps_submem
  import zps_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [HALF_W-1:0]             waddr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic [NPORT-1:0][HALF_W-1:0]  raddr,
  output logic [NPORT-1:0][BYTE_W-1:0]  rdata
);
  logic [BYTE_W-1:0] mem [HALF_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

  // R8: a byte written on one edge is held by the next
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/zps_bank.sv
module zps_bank
  import zps_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [OFF_W-1:0]             woff,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic [NPORT-1:0]             re,
  input  logic [NPORT-1:0][OFF_W-1:0]  roff,
  input  logic [NPORT-1:0]             rword,
  output logic [NPORT-1:0][WORD_W-1:0] rdata
);
  // half 0 holds even offsets, half 1 holds odd offsets
  logic [1:0][NPORT-1:0][HALF_W-1:0] half_idx;
  logic [1:0][NPORT-1:0][BYTE_W-1:0] half_q;
  logic [NPORT-1:0][OFF_W-1:0]       lo_off, hi_off;
  logic [NPORT-1:0][BYTE_W-1:0]      lo_val, hi_val;
  logic [NPORT-1:0][WORD_W-1:0]      rdata_d;

  for (genvar h = 0; h < 2; h++) begin : g_half
    zps_submem #(.NPORT(NPORT)) u_sub (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we && (woff[0] == 1'(h))),
      .waddr (woff[OFF_W-1:1]),
      .wdata (wdata),
      .raddr (half_idx[h]),
      .rdata (half_q[h])
    );
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      lo_off[p] = roff[p];
      hi_off[p] = next_off(roff[p]);
      // odd start: low byte in odd half, high byte at next even slot (may wrap)
      half_idx[0][p] = lo_off[p][0] ? hi_off[p][OFF_W-1:1] : lo_off[p][OFF_W-1:1];
      half_idx[1][p] = lo_off[p][OFF_W-1:1];
      lo_val[p] = pick_byte(we, woff, wdata, lo_off[p],
                            lo_off[p][0] ? half_q[1][p] : half_q[0][p]);
      hi_val[p] = pick_byte(we, woff, wdata, hi_off[p],
                            lo_off[p][0] ? half_q[0][p] : half_q[1][p]);
      if (!re[p])        rdata_d[p] = '0;
      else if (rword[p]) rdata_d[p] = {hi_val[p], lo_val[p]};
      else               rdata_d[p] = {{BYTE_W{1'b0}}, lo_val[p]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R9: high lane of a word read sees a same-cycle write to its byte
  assert_hi_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && re[0] && rword[0] && (next_off(roff[0]) == woff))
      |=> rdata[0][WORD_W-1:BYTE_W] == $past(wdata));
endmodule

// File: rtl/zp_stack_store.sv
module zp_stack_store
  import zps_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  localparam int SEL_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_word,
  output logic              a_hit,
  output logic              a_ext,
  output logic [WORD_W-1:0] a_data,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_word,
  output logic              b_hit,
  output logic              b_ext,
  output logic [WORD_W-1:0] b_data,
  input  logic              w_en,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [BYTE_W-1:0] w_data,
  output logic              w_ext
);
  logic [SEL_W-1:0] a_sel, b_sel, w_sel;
  logic [OFF_W-1:0] a_off, b_off, w_off;
  logic             w_hit, w_miss;

  zps_decode #(.NUM_PAGES(NUM_PAGES)) u_dec_a (
    .addr(a_addr), .hit(a_hit), .ext(a_ext), .sel(a_sel), .off(a_off));
  zps_decode #(.NUM_PAGES(NUM_PAGES)) u_dec_b (
    .addr(b_addr), .hit(b_hit), .ext(b_ext), .sel(b_sel), .off(b_off));
  zps_decode #(.NUM_PAGES(NUM_PAGES)) u_dec_w (
    .addr(w_addr), .hit(w_hit), .ext(w_miss), .sel(w_sel), .off(w_off));

  assign w_ext = w_en && w_miss;

  logic [NUM_PAGES-1:0]                         bank_we;
  logic [NUM_PAGES-1:0][NPORT-1:0]              bank_re;
  logic [NUM_PAGES-1:0][NPORT-1:0][WORD_W-1:0]  bank_q;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_bank
    assign bank_we[g] = w_en && w_hit && (w_sel == SEL_W'(g));
    assign bank_re[g] = {b_hit && (b_sel == SEL_W'(g)),
                         a_hit && (a_sel == SEL_W'(g))};
    zps_bank #(.NPORT(NPORT)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[g]),
      .woff  (w_off),
      .wdata (w_data),
      .re    (bank_re[g]),
      .roff  ({b_off, a_off}),
      .rword ({b_word, a_word}),
      .rdata (bank_q[g])
    );
  end

  // unselected banks drive zero, so an OR merges the page outputs
  always_comb begin
    a_data = '0;
    b_data = '0;
    for (int g = 0; g < NUM_PAGES; g++) begin
      a_data = a_data | bank_q[g][0];
      b_data = b_data | bank_q[g][1];
    end
  end

  // R1: a write reaches at most one page bank
  assert_one_bank_we_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R10: an external write touches no bank
  assert_ext_write_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w_ext |-> (bank_we == '0));

  // R10: an external read yields zero data next cycle
  assert_ext_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ext || b_ext) |=> ((!$past(a_ext) || a_data == '0) &&
                          (!$past(b_ext) || b_data == '0)));

  // R3: byte reads leave the upper lane clear
  assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !a_word |=> a_data[WORD_W-1:BYTE_W] == '0);

  // R9: same-cycle write to the low-lane byte is returned
  assert_lo_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && w_hit && a_hit && (a_addr == w_addr))
      |=> a_data[BYTE_W-1:0] == $past(w_data));
endmodule

// File: tb/zp_stack_store_test.sv
module zp_stack_store_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] a_addr, b_addr, w_addr;
  logic        a_word, b_word, w_en;
  logic [7:0]  w_data;
  logic        a_hit, a_ext, b_hit, b_ext, w_ext;
  logic [15:0] a_data, b_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  zp_stack_store uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_word(a_word), .a_hit(a_hit), .a_ext(a_ext), .a_data(a_data),
    .b_addr(b_addr), .b_word(b_word), .b_hit(b_hit), .b_ext(b_ext), .b_data(b_data),
    .w_en(w_en), .w_addr(w_addr), .w_data(w_data), .w_ext(w_ext)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit inside_pages(logic [15:0] a);
    return a[15:9] == 7'd0;
  endfunction

  function automatic logic [15:0] model_read(logic [15:0] a, logic word);
    logic [7:0] o1;
    if (!inside_pages(a)) return 16'h0000;
    o1 = a[7:0] + 8'd1;
    return {word ? shadow[{a[8], o1}] : 8'h00, shadow[{a[8], a[7:0]}]};
  endfunction

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 7 + 3) ^ ((i >= 256) ? 8'hC3 : 8'h00));
  endfunction

  task automatic do_write(input logic [15:0] addr, input logic [7:0] data, input string tag);
    @(negedge clk);
    w_en = 1'b1; w_addr = addr; w_data = data;
    #1 chk({tag, " R2 w_ext"}, {15'd0, w_ext}, {15'd0, !inside_pages(addr)});
    @(posedge clk);
    if (inside_pages(addr)) shadow[addr[8:0]] = data;
    @(negedge clk);
    w_en = 1'b0;
  endtask

  task automatic read_pair(input logic [15:0] aa, input logic aw,
                           input logic [15:0] ba, input logic bw, input string tag);
    logic [15:0] ea, eb;
    @(negedge clk);
    a_addr = aa; a_word = aw; b_addr = ba; b_word = bw;
    ea = model_read(aa, aw);
    eb = model_read(ba, bw);
    #1;
    chk({tag, " R2 a_hit"}, {15'd0, a_hit}, {15'd0, inside_pages(aa)});
    chk({tag, " R2 a_ext"}, {15'd0, a_ext}, {15'd0, !inside_pages(aa)});
    chk({tag, " R2 b_hit"}, {15'd0, b_hit}, {15'd0, inside_pages(ba)});
    chk({tag, " R2 b_ext"}, {15'd0, b_ext}, {15'd0, !inside_pages(ba)});
    @(posedge clk);
    @(negedge clk);
    chk({tag, " a_data"}, a_data, ea);
    chk({tag, " b_data"}, b_data, eb);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; w_en = 1'b0; w_addr = '0; w_data = '0;
    a_addr = 16'h0010; a_word = 1'b1; b_addr = 16'h0110; b_word = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 a_data in reset", a_data, 16'h0000);
    chk("R11 b_data in reset", b_data, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic t_fill;
    for (int i = 0; i < 512; i++) do_write(16'(i), pattern(i), "R1 fill");
    read_pair(16'h0005, 1'b0, 16'h0105, 1'b0, "R1 R3 page split");
    do_write(16'h0005, 8'h99, "R1 rewrite");
    read_pair(16'h0005, 1'b0, 16'h0105, 1'b0, "R1 page0 write leaves page1");
    read_pair(16'h00A7, 1'b0, 16'h01FE, 1'b0, "R3 byte reads");
  endtask

  task automatic t_redirect;
    read_pair(16'h0000, 1'b0, 16'h01FF, 1'b0, "R2 internal edges");
    read_pair(16'h0200, 1'b0, 16'hFF00, 1'b1, "R2 R10 external reads");
    read_pair(16'h8001, 1'b1, 16'h00FE, 1'b0, "R2 mixed");
  endtask

  task automatic t_words;
    read_pair(16'h0040, 1'b1, 16'h0041, 1'b1, "R4 even odd page0");
    read_pair(16'h0182, 1'b1, 16'h01C3, 1'b1, "R4 even odd page1");
  endtask

  task automatic t_wrap;
    read_pair(16'h00FF, 1'b1, 16'h01FF, 1'b1, "R5 R6 page wrap");
    chk("R5 zp high byte from 0x0000", {8'h00, a_data[15:8]}, {8'h00, shadow[9'h000]});
    chk("R6 stack high byte from 0x0100", {8'h00, b_data[15:8]}, {8'h00, shadow[9'h100]});
  endtask

  task automatic t_dual;
    read_pair(16'h0011, 1'b1, 16'h0011, 1'b1, "R7 same page same addr");
    read_pair(16'h0120, 1'b0, 16'h0033, 1'b1, "R7 different pages");
  endtask

  task automatic t_push;
    do_write(16'h01FD, 8'h12, "R8 push hi");
    do_write(16'h01FC, 8'hC4, "R8 push lo");
    read_pair(16'h01FC, 1'b1, 16'h01FD, 1'b0, "R8 pulled word");
    chk("R8 word value", a_data, 16'h12C4);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    w_en = 1'b1; w_addr = 16'h0031; w_data = 8'h5E;
    a_addr = 16'h0031; a_word = 1'b0; b_addr = 16'h0030; b_word = 1'b1;
    @(posedge clk);
    shadow[9'h031] = 8'h5E;
    @(negedge clk);
    w_en = 1'b0;
    chk("R9 port A low lane", a_data, 16'h005E);
    chk("R9 port B high lane", b_data, {8'h5E, shadow[9'h030]});
    @(negedge clk);
    w_en = 1'b1; w_addr = 16'h0100; w_data = 8'hA1;
    a_addr = 16'h01FF; a_word = 1'b1; b_addr = 16'h0100; b_word = 1'b0;
    @(posedge clk);
    shadow[9'h100] = 8'hA1;
    @(negedge clk);
    w_en = 1'b0;
    chk("R9 port A wrapped high lane", a_data, {8'hA1, shadow[9'h1FF]});
    chk("R9 port B page1 byte", b_data, 16'h00A1);
  endtask

  task automatic t_ext_write;
    do_write(16'h0205, 8'h77, "R10 ext write");
    do_write(16'hFF01, 8'h66, "R10 ext write high");
    read_pair(16'h0005, 1'b1, 16'h0101, 1'b0, "R10 banks untouched");
    chk("R10 0x0005 kept", a_data[7:0], 8'h99);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_redirect();
    t_words();
    t_wrap();
    t_dual();
    t_push();
    t_bypass();
    t_ext_write();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule